// File: doc/BRIEF.md
# Handshaked Byte-Stream Link Controller

This block sits between a host and a local controller and moves whole packets of bytes across an 8-bit shift-register window. The host owns two active-low strobes: an in-progress line that frames a transfer and an acknowledge line that it toggles once per byte. The controller answers on one active-low request line. A direction input chooses whether the host is sending bytes to the controller or collecting bytes from it.

Each byte moves when the pair of host strobes changes state, not on a bit clock. Bytes sent by the host go into a 16-entry outbound store. When the host closes the transfer, the local side gets a one-cycle packet notice carrying the byte count and can then read the bytes by address. The local side fills a 128-entry inbound store one byte at a time and commits a length. The block then raises the request line so that the host comes to collect the packet. When the last byte has been handed out, the block releases the request line to mark the end of the packet.

Top module: `hsk_byte_link`

## Requirements
- R1: After reset, `treq_n` is 1, `sr_q` is 0, and `sr_event` and `pkt_valid` are 0.
- R2: While `tip_n` is 0, `h2c_dir` is 0 and inbound bytes remain, any change of the pair {`tip_n`,`ack_n`} loads the next inbound byte into `sr_q` and pulses `sr_event`, both visible one cycle later. `sr_q` never changes while `tip_n` is 1.
- R3: While `tip_n` is 0 and `h2c_dir` is 1, each change of the pair appends `sr_in` to the outbound store and pulses `sr_event`. Only the first 16 bytes are kept. Later bytes are dropped, but each one still pulses `sr_event`.
- R4: A pair change during a controller-to-host transfer with no inbound byte left leaves `sr_q` unchanged and gives no `sr_event`.
- R5: The cycle after the last inbound byte is loaded into `sr_q`, `treq_n` is 1.
- R6: On the first cycle with `tip_n` at 1 after a cycle with `tip_n` at 0, `sr_event` pulses. If any bytes were collected, `pkt_valid` also pulses, with `pkt_len` equal to the kept count. Those bytes can be read on `out_rd_data` at `out_rd_addr` 0 to `pkt_len`-1 until the next transfer, and the store index returns to 0.
- R7: On a cycle where `tip_n` is 1 and inbound bytes remain, `treq_n` is 0 on the next cycle.
- R8: When `tip_n` is 1 on two consecutive cycles and nothing is pending, a change of `ack_n` sets `treq_n` to the new `ack_n` value on the next cycle.
- R9: A `q_commit` pulse sets the inbound length to `q_len`, limited to 128, restarts the read position at byte 0 and pulses `sr_event`. If `tip_n` is 0 when the pulse arrives, the commit is held and takes effect on the first cycle with `tip_n` at 1. A newer commit replaces a held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| ack_n | input | 1 | Host byte acknowledge, active low |
| h2c_dir | input | 1 | 1: host sends to controller, 0: controller sends to host |
| sr_in | input | 8 | Byte the host places in the window |
| treq_n | output | 1 | Controller transfer request, active low |
| sr_q | output | 8 | Byte the controller places in the window |
| sr_event | output | 1 | One-cycle shift-window interrupt pulse |
| q_wr | input | 1 | Write one inbound store byte |
| q_addr | input | 7 | Inbound store write address |
| q_wdata | input | 8 | Inbound store write data |
| q_commit | input | 1 | Queue the inbound store contents as a packet |
| q_len | input | 8 | Length of the queued packet |
| pkt_valid | output | 1 | One-cycle notice that a host packet arrived |
| pkt_len | output | 5 | Byte count of the arrived packet |
| out_rd_addr | input | 4 | Outbound store read address |
| out_rd_data | output | 8 | Outbound store byte at `out_rd_addr` |

## Verification
The assertions assume that the host changes its strobes at most once per clock. They also assume that the local side does not write the inbound store while a committed packet is still being collected or while a commit is held. The bench drives every host strobe and local write on the falling edge, one change per cycle, and loads inbound bytes only when nothing is pending. A behavioural model built from queues tracks the request line, the window byte and both pulses, and is compared with the design on every clock. Directed checks cover overflow, held commits, length clamping and the idle acknowledge mirror.

// File: rtl/hsk_byte_link.sv
module hsk_byte_link #(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OAW = $clog2(OUT_DEPTH + 1),
  localparam int ORW = $clog2(OUT_DEPTH),
  localparam int IAW = $clog2(IN_DEPTH),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tip_n,
  input  logic           ack_n,
  input  logic           h2c_dir,
  input  logic [7:0]     sr_in,
  output logic           treq_n,
  output logic [7:0]     sr_q,
  output logic           sr_event,
  input  logic           q_wr,
  input  logic [IAW-1:0] q_addr,
  input  logic [7:0]     q_wdata,
  input  logic           q_commit,
  input  logic [ICW-1:0] q_len,
  output logic           pkt_valid,
  output logic [OAW-1:0] pkt_len,
  input  logic [ORW-1:0] out_rd_addr,
  output logic [7:0]     out_rd_data
);

  logic [7:0]     obuf [OUT_DEPTH];
  logic [7:0]     ibuf [IN_DEPTH];
  logic           prev_tip_n, prev_ack_n;
  logic [OAW-1:0] out_idx;
  logic [ICW-1:0] in_idx, in_size;
  logic           hold_v;
  logic [ICW-1:0] hold_len;

  wire active   = !tip_n;
  wire pair_chg = (tip_n != prev_tip_n) || (ack_n != prev_ack_n);
  wire pending  = in_idx < in_size;
  wire [ICW-1:0] len_c = (q_len > ICW'(IN_DEPTH)) ? ICW'(IN_DEPTH) : q_len;
  wire apply    = !active && (hold_v || q_commit);
  wire [ICW-1:0] apply_len = q_commit ? len_c : hold_len;
  wire h2c_step = active && pair_chg && h2c_dir;
  wire store    = h2c_step && (out_idx < OAW'(OUT_DEPTH));
  wire c2h_step = active && pair_chg && !h2c_dir && pending;
  wire xfer_end = !active && !prev_tip_n;
  wire last_out = c2h_step && (ICW'(in_idx + 1'b1) == in_size);

  assign out_rd_data = obuf[out_rd_addr];

  always_ff @(posedge clk) begin
    if (store) obuf[out_idx[ORW-1:0]] <= sr_in;
    if (q_wr)  ibuf[q_addr] <= q_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tip_n <= 1'b1;
      prev_ack_n <= 1'b1;
      treq_n     <= 1'b1;
      sr_q       <= '0;
      sr_event   <= 1'b0;
      pkt_valid  <= 1'b0;
      pkt_len    <= '0;
      out_idx    <= '0;
      in_idx     <= '0;
      in_size    <= '0;
      hold_v     <= 1'b0;
      hold_len   <= '0;
    end else begin
      prev_tip_n <= tip_n;
      prev_ack_n <= ack_n;
      sr_event   <= h2c_step || c2h_step || xfer_end || apply;
      pkt_valid  <= xfer_end && (out_idx != '0);
      if (xfer_end && (out_idx != '0)) pkt_len <= out_idx;

      if (store)         out_idx <= out_idx + 1'b1;
      else if (xfer_end) out_idx <= '0;

      if (c2h_step) begin
        sr_q   <= ibuf[in_idx[IAW-1:0]];
        in_idx <= in_idx + 1'b1;
      end
      if (apply) begin
        in_size <= apply_len;
        in_idx  <= '0;
      end

      if (active && q_commit) begin
        hold_v   <= 1'b1;
        hold_len <= len_c;
      end else if (apply) begin
        hold_v <= 1'b0;
      end

      if (last_out) treq_n <= 1'b1;
      else if (!active) begin
        if (pending) treq_n <= 1'b0;
        else if (prev_tip_n && (ack_n != prev_ack_n)) treq_n <= ack_n;
      end
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_idx <= OAW'(OUT_DEPTH));

  p_idle_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tip_n |=> $stable(sr_q));

  p_end_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tip_n && !h2c_dir && pair_chg && pending && (in_size - in_idx == ICW'(1))) |=> treq_n);

  p_pkt_notice_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0) && (pkt_len <= OAW'(OUT_DEPTH)) && (out_idx == '0));

  p_pending_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tip_n && pending) |=> !treq_n);

  p_idle_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tip_n && prev_tip_n && !pending && (ack_n != prev_ack_n)) |=> (treq_n == $past(ack_n)));

  p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && tip_n) |=> !hold_v);

  p_hold_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_commit && !tip_n) |=> hold_v);

endmodule

// File: tb/hsk_byte_link_bench.sv
`timescale 1ns/1ps
module hsk_byte_link_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic tip_n = 1, ack_n = 1, h2c_dir = 0;
  logic [7:0] sr_in = 0;
  logic q_wr = 0, q_commit = 0;
  logic [6:0] q_addr = 0;
  logic [7:0] q_wdata = 0, q_len = 0;
  logic [3:0] out_rd_addr = 0;
  wire treq_n, sr_event, pkt_valid;
  wire [7:0] sr_q, out_rd_data;
  wire [4:0] pkt_len;

  hsk_byte_link u_hsk_byte_link (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .h2c_dir(h2c_dir),
    .sr_in(sr_in), .treq_n(treq_n), .sr_q(sr_q), .sr_event(sr_event),
    .q_wr(q_wr), .q_addr(q_addr), .q_wdata(q_wdata), .q_commit(q_commit),
    .q_len(q_len), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data));

  int total = 0, bad = 0;
  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  logic [7:0] m_img [128];
  logic [7:0] m_oq[$], m_iq[$];
  bit m_ptip = 1, m_pack = 1, m_treq = 1, m_ev = 0, m_pv = 0, m_hv = 0;
  logic [7:0] m_sr = 0;
  int m_plen = 0, m_hl = 0;

  always @(posedge clk) begin : model
    bit chg;
    int nlen, n;
    if (!rst_n) begin
      m_ptip = 1; m_pack = 1; m_treq = 1; m_ev = 0; m_pv = 0; m_hv = 0; m_sr = 0;
      m_oq.delete(); m_iq.delete();
    end else begin
      chg  = (tip_n != m_ptip) || (ack_n != m_pack);
      nlen = (q_len > 128) ? 128 : int'(q_len);
      m_ev = 0; m_pv = 0;
      if (!tip_n) begin
        if (q_commit) begin m_hv = 1; m_hl = nlen; end
        if (chg && h2c_dir) begin
          if (m_oq.size() < 16) m_oq.push_back(sr_in);
          m_ev = 1;
        end else if (chg && m_iq.size() > 0) begin
          m_sr = m_iq.pop_front();
          m_ev = 1;
          if (m_iq.size() == 0) m_treq = 1;
        end
      end else begin
        if (m_ptip && ack_n != m_pack) m_treq = ack_n;
        if (!m_ptip) begin
          m_ev = 1;
          if (m_oq.size() > 0) begin m_pv = 1; m_plen = m_oq.size(); m_oq.delete(); end
        end
        if (m_iq.size() > 0) m_treq = 0;
        if (q_commit || m_hv) begin
          n = q_commit ? nlen : m_hl;
          m_iq.delete();
          for (int i = 0; i < n; i++) m_iq.push_back(m_img[i]);
          m_ev = 1; m_hv = 0;
        end
      end
      if (q_wr) m_img[q_addr] = q_wdata;
      m_ptip = tip_n; m_pack = ack_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R5/R7/R8 model treq_n", treq_n, m_treq);
    chk("R2/R4 model sr_q", sr_q, m_sr);
    chk("R3/R6/R9 model sr_event", sr_event, m_ev);
    chk("R6 model pkt_valid", pkt_valid, m_pv);
    if (m_pv) chk("R6 model pkt_len", pkt_len, m_plen);
  end

  task automatic load(input logic [7:0] d[$]);
    for (int i = 0; i < d.size(); i++) begin
      @(negedge clk); q_wr = 1; q_addr = 7'(i); q_wdata = d[i];
    end
    @(negedge clk); q_wr = 0;
  endtask

  task automatic commit(input int len);
    @(negedge clk); q_commit = 1; q_len = 8'(len);
    @(negedge clk); q_commit = 0;
  endtask

  task automatic host_send(input logic [7:0] d[$], input int expect_len);
    h2c_dir = 1;
    @(negedge clk); sr_in = d[0]; tip_n = 0;
    for (int i = 1; i < d.size(); i++) begin
      @(negedge clk); sr_in = d[i]; ack_n = ~ack_n;
    end
    @(negedge clk); tip_n = 1;
    @(negedge clk);
    chk("R6 pkt_valid at close", pkt_valid, 1);
    chk("R3 pkt_len kept count", pkt_len, expect_len);
    for (int i = 0; i < expect_len; i++) begin
      out_rd_addr = 4'(i); #1;
      chk("R3 stored byte", out_rd_data, d[i]);
      @(negedge clk);
    end
  endtask

  task automatic host_read(input logic [7:0] d[$], input int cnt, input bit extra);
    h2c_dir = 0;
    @(negedge clk); tip_n = 0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      chk("R2 window byte", sr_q, d[i]);
      if (i == d.size() - 1) chk("R5 end of packet treq_n", treq_n, 1);
      if (i < cnt - 1) ack_n = ~ack_n;
    end
    if (extra) begin
      ack_n = ~ack_n;
      @(negedge clk);
      chk("R4 no byte left sr_q", sr_q, d[d.size()-1]);
      chk("R4 no byte left sr_event", sr_event, 0);
    end
    tip_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] a[$], b[$], c[$], e[$];
    repeat (3) @(negedge clk);
    chk("R1 reset treq_n", treq_n, 1);
    chk("R1 reset sr_q", sr_q, 0);
    chk("R1 reset sr_event", sr_event, 0);
    chk("R1 reset pkt_valid", pkt_valid, 0);
    rst_n = 1;
    @(negedge clk);

    a = '{8'h11, 8'h22, 8'h33};
    host_send(a, 3);

    b.delete();
    for (int i = 0; i < 18; i++) b.push_back(8'(8'hA0 + i));
    host_send(b, 16);

    c = '{8'h5A, 8'hC3, 8'h01, 8'hFE, 8'h7E};
    load(c);
    commit(5);
    @(negedge clk);
    chk("R7 treq_n asserted for pending data", treq_n, 0);
    host_read(c, 5, 1);
    chk("R5 treq_n stays released", treq_n, 1);

    e = '{8'h10, 8'h20, 8'h30, 8'h40};
    load(e);
    commit(4);
    @(negedge clk);
    host_read(e, 2, 0);
    @(negedge clk);
    chk("R7 treq_n again after partial read", treq_n, 0);
    e = '{8'h30, 8'h40};
    host_read(e, 2, 0);

    @(negedge clk); ack_n = ~ack_n;
    @(negedge clk); chk("R8 treq_n mirrors ack_n", treq_n, int'(ack_n));
    ack_n = ~ack_n;
    @(negedge clk); chk("R8 treq_n mirrors ack_n again", treq_n, int'(ack_n));

    c = '{8'h99, 8'h88, 8'h77};
    load(c);
    h2c_dir = 1;
    @(negedge clk); sr_in = 8'h42; tip_n = 0;
    @(negedge clk); q_commit = 1; q_len = 8'd3;
    @(negedge clk); q_commit = 0;
    @(negedge clk); chk("R9 commit held during transfer", treq_n, 1);
    tip_n = 1;
    @(negedge clk); chk("R9 event on release", sr_event, 1);
    chk("R6 pkt_len single byte", pkt_len, 1);
    @(negedge clk); chk("R9 held packet now pending", treq_n, 0);
    host_read(c, 3, 0);

    b.delete();
    for (int i = 0; i < 128; i++) b.push_back(8'(i ^ 8'h5A));
    load(b);
    commit(200);
    @(negedge clk);
    host_read(b, 128, 1);
    chk("R9 clamp leaves nothing pending", treq_n, 1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule